// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine with Selectable Initial Value

This block computes a 16-bit cyclic redundancy check over a stream of bytes, absorbing one byte per clock. A start strobe loads one of four fixed initial values, chosen by a 2-bit select input, into the checksum register. Every byte that is presented while a calculation is open is then folded in. The stream may be of any length. The calculation closes when the byte source reports that it is empty.

The generator is x^16 + x^12 + x^5 + 1. Each byte is applied least significant bit first, which uses the bit-reversed constant 8408h, and no final inversion is applied. The result is presented as two separate byte outputs. A completion flag remains set until the next start strobe. An interrupt line carries that flag only while the enable input is high.

Top module: `crc16_engine`

## Requirements
- R1: After reset, `crc_hi` and `crc_lo` are 00h, and `done` and `irq` are 0.
- R2: On the clock edge that samples `start`, the register is loaded from `preset_sel` (00 → 0000h, 01 → 6363h, 10 → A671h, 11 → FFFFh). `done` is 0 from the next cycle onward.
- R3: Each byte with `byte_valid` high during an open calculation updates the register in that same edge. The update is eight LSB-first steps of the reflected polynomial 8408h, with no final XOR. The preset 6363h followed by bytes 00h, 00h gives 1EA0h. The preset FFFFh over ASCII "123456789" gives 6F91h.
- R4: `byte_valid` has no effect on the result while no calculation is open, either after reset or after completion.
- R5: The length of the stream is not limited. A 100-byte stream matches a bit-serial reference.
- R6: An edge that samples `src_empty` high during an open calculation closes it and sets `done` for the following cycle. A byte presented in that same cycle is still absorbed.
- R7: `done` stays 1 until the edge that samples the next `start`.
- R8: `irq` equals `done` AND `irq_en`, combinationally.
- R9: When `start` and `byte_valid` fall in the same cycle, the byte is discarded and the register holds exactly the preset.
- R10: `crc_hi` is bits 15:8 of the checksum and `crc_lo` is bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a calculation and loads the preset |
| preset_sel | input | 2 | Selects the initial value |
| byte_valid | input | 1 | A byte is present on `byte_in` |
| byte_in | input | 8 | Input data byte |
| src_empty | input | 1 | The byte source is empty and the stream ends |
| irq_en | input | 1 | Passes `done` to `irq` |
| crc_hi | output | 8 | Checksum high byte |
| crc_lo | output | 8 | Checksum low byte |
| done | output | 1 | Calculation completed, held until the next start |
| irq | output | 1 | Gated completion request |

## Verification
Two pairs of events can coincide. The last data byte can arrive in the same cycle as the end-of-stream indication, and a start strobe can arrive together with a valid byte. The bench drives each pair in a single cycle. In the first case it expects `done` one cycle later and a checksum that includes that byte, as computed by a bit-serial model. In the second case it expects the bare preset on the outputs, with the colliding byte dropped.

// File: rtl/crc16_engine.sv
module crc16_engine #(
  parameter logic [15:0] POLY_REFL = 16'h8408,
  parameter logic [15:0] INIT_A    = 16'h0000,
  parameter logic [15:0] INIT_B    = 16'h6363,
  parameter logic [15:0] INIT_C    = 16'hA671,
  parameter logic [15:0] INIT_D    = 16'hFFFF,
  parameter int          DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    preset_sel,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  input  logic          src_empty,
  input  logic          irq_en,
  output logic [7:0]    crc_hi,
  output logic [7:0]    crc_lo,
  output logic          done,
  output logic          irq
);
  localparam int CW = 16;

  logic [CW-1:0] crc_q;
  logic          busy_q;
  logic [CW-1:0] preset;
  logic [CW-1:0] crc_next;

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c, input logic [DW-1:0] d);
    logic [CW-1:0] r;
    r = c ^ {{(CW-DW){1'b0}}, d};
    for (int i = 0; i < DW; i++)
      r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    return r;
  endfunction

  always_comb begin
    case (preset_sel)
      2'b00:   preset = INIT_A;
      2'b01:   preset = INIT_B;
      2'b10:   preset = INIT_C;
      default: preset = INIT_D;
    endcase
  end

  assign crc_next = fold(crc_q, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      crc_q  <= preset;
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      if (byte_valid) crc_q <= crc_next;
      if (src_empty) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign crc_hi = crc_q[15:8];
  assign crc_lo = crc_q[7:0];
  assign irq    = done & irq_en;

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R7
  AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    start && preset_sel == 2'b11 |=> {crc_hi, crc_lo} == 16'hFFFF); // R2
  AST_PRESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start && preset_sel == 2'b00 |=> {crc_hi, crc_lo} == 16'h0000); // R9
  AST_CLOSE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && src_empty && !start |=> done); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> $stable({crc_hi, crc_lo})); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q); // R4
endmodule

// File: tb/crc16_engine_test.sv
module crc16_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] preset_sel = 2'b00;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       src_empty = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] crc_hi, crc_lo;
  logic       done, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc16_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .preset_sel(preset_sel),
    .byte_valid(byte_valid), .byte_in(byte_in), .src_empty(src_empty),
    .irq_en(irq_en), .crc_hi(crc_hi), .crc_lo(crc_lo), .done(done), .irq(irq)
  );

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic logic [15:0] init_of(input logic [1:0] s);
    case (s)
      2'b00: return 16'h0000;
      2'b01: return 16'h6363;
      2'b10: return 16'hA671;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_calc(input logic [1:0] s);
    start = 1'b1; preset_sel = s; tick(); start = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    byte_valid = 1'b1; byte_in = d; tick(); byte_valid = 1'b0;
  endtask

  task automatic close_calc();
    src_empty = 1'b1; tick(); src_empty = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 crc", {crc_hi, crc_lo}, 16'h0000);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    push(8'h5A);
    chk("R4 byte before any start", {crc_hi, crc_lo}, 16'h0000);
  endtask

  task automatic t_presets();
    for (int s = 0; s < 4; s++) begin
      open_calc(s[1:0]);
      chk("R2 preset", {crc_hi, crc_lo}, init_of(s[1:0]));
      chk("R10 high byte", {8'h00, crc_hi}, {8'h00, init_of(s[1:0]) >> 8});
      chk("R2 done low", {15'd0, done}, 16'd0);
    end
    close_calc();
  endtask

  task automatic t_vectors();
    logic [15:0] m;
    logic [7:0] msg [9];
    open_calc(2'b01);
    push(8'h00); push(8'h00);
    chk("R3 6363 00 00", {crc_hi, crc_lo}, 16'h1EA0);
    close_calc();
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    open_calc(2'b11);
    m = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin push(msg[i]); m = ref_byte(m, msg[i]); end
    chk("R3 FFFF 123456789", {crc_hi, crc_lo}, 16'h6F91);
    chk("R3 model", {crc_hi, crc_lo}, m);
    close_calc();
  endtask

  task automatic t_long();
    logic [15:0] m;
    open_calc(2'b10);
    m = 16'hA671;
    for (int i = 0; i < 100; i++) begin
      push(8'(i * 7 + 3)); m = ref_byte(m, 8'(i * 7 + 3));
    end
    chk("R5 long stream", {crc_hi, crc_lo}, m);
    close_calc();
    chk("R5 done", {15'd0, done}, 16'd1);
  endtask

  task automatic t_last_with_empty();
    logic [15:0] m;
    open_calc(2'b00);
    push(8'hC3);
    m = ref_byte(16'h0000, 8'hC3);
    chk("R6 not done yet", {15'd0, done}, 16'd0);
    byte_valid = 1'b1; byte_in = 8'h7E; src_empty = 1'b1;
    tick();
    byte_valid = 1'b0; src_empty = 1'b0;
    m = ref_byte(m, 8'h7E);
    chk("R6 done next cycle", {15'd0, done}, 16'd1);
    chk("R6 last byte absorbed", {crc_hi, crc_lo}, m);
    push(8'h11);
    chk("R4 byte after done", {crc_hi, crc_lo}, m);
  endtask

  task automatic t_hold_and_irq();
    for (int i = 0; i < 5; i++) tick();
    chk("R7 done held", {15'd0, done}, 16'd1);
    irq_en = 1'b0; #1;
    chk("R8 irq masked", {15'd0, irq}, 16'd0);
    irq_en = 1'b1; #1;
    chk("R8 irq passes", {15'd0, irq}, 16'd1);
    open_calc(2'b01);
    chk("R7 start clears done", {15'd0, done}, 16'd0);
    chk("R8 irq follows done", {15'd0, irq}, 16'd0);
    close_calc();
    chk("R8 irq on completion", {15'd0, irq}, 16'd1);
    irq_en = 1'b0;
  endtask

  task automatic t_collision();
    start = 1'b1; preset_sel = 2'b10; byte_valid = 1'b1; byte_in = 8'hFF;
    tick();
    start = 1'b0; byte_valid = 1'b0;
    chk("R9 byte dropped on start", {crc_hi, crc_lo}, 16'hA671);
    push(8'h01);
    chk("R9 next byte absorbed", {crc_hi, crc_lo}, ref_byte(16'hA671, 8'h01));
    close_calc();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_presets();
    t_vectors();
    t_long();
    t_last_with_empty();
    t_hold_and_irq();
    t_collision();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule